// File: doc/BRIEF.md
# Period and Tempo Interrupt Controller

This block raises two kinds of interrupt. The first is a period interrupt. It is raised on every pulse of an external period tick, which runs at 37.5 kHz in the intended system. The second is a tempo interrupt. It is raised once every N period ticks, with N = X + 2, where X is a 12-bit limit supplied on an input port. X = 0 gives N = 2 and X = 4095 gives N = 4097. The tempo divider is an overflow counter compared with `>=`, so X may be changed at any moment and the divider never stalls.

A single 4-bit status/enable register holds both pending flags and both enable flags. Software writes it with a set/clear convention: bit 7 of the written byte chooses set or clear, and only the 1-bits of the low nibble act. The request line is high while an enabled interrupt is pending. On an acknowledge strobe the block supplies a vector byte: 8'hF7 for tempo, which wins when both are requested, or 8'hFF for period. The same strobe clears the pending flag of the interrupt that was acknowledged.

Top module: `tempo_irq_ctrl`

## Requirements
- R1: After reset the register reads 0, `irq_o` is 0 and `vec_o` is 8'hFF.
- R2: Register layout is bit 3 tempo enable, bit 2 tempo pending, bit 1 period enable, bit 0 period pending. `rd_data_o[7:4]` reads 0.
- R3: A write with data bit 7 = 1 sets every register bit whose data bit in [3:0] is 1. A write with bit 7 = 0 clears those bits. Register bits whose data bit is 0 are unchanged.
- R4: A cycle with `tick_i` high sets period pending (bit 0). The flag is readable from the next cycle.
- R5: With limit X held constant from reset, the first tempo event comes on tick X+1. After that, tempo events come every X+2 ticks. Each tempo event sets tempo pending (bit 2).
- R6: Lowering X while the count already exceeds it makes a tempo event on the very next tick. The count then continues with period X+2.
- R7: `irq_o` is high exactly when (bit 0 and bit 1) or (bit 2 and bit 3) are set.
- R8: While a tempo request exists, `vec_o` is 8'hF7. Otherwise it is 8'hFF. When both are requested, tempo wins.
- R9: `ack_i` while `irq_o` is high clears only the pending bit of the interrupt shown on `vec_o`. `ack_i` while `irq_o` is low has no effect.
- R10: A pending set by a tick or a register write in the same cycle as an acknowledge wins over the clear.
- R11: On a tick where both events occur, both pending bits are set, and tempo is presented first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle period tick pulse |
| limit_i | input | 12 | Tempo limit X (N = X + 2) |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Write data: bit 7 set/clear, [3:0] bit select |
| rd_data_o | output | 8 | Register readback |
| ack_i | input | 1 | Interrupt acknowledge (vector read) |
| vec_o | output | 8 | Acknowledge vector byte |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench measures tempo spacing at the smallest limit and at a mid limit. A compare using `==` instead of `>=`, or a counter with an off-by-one, shows up as wrong spacing. It also lowers the limit below a count already reached. A design using `==` would then miss the event and would not fire for a full counter wrap. Further cases are an acknowledge with no request, which must change nothing, and acknowledges that coincide with a new tick. A design that let the clear win there would lose an interrupt. A tick that raises both events must present tempo first and then period.

// File: rtl/tirq_pkg.sv
package tirq_pkg;
  localparam int unsigned BIT_PER_PEND = 0;
  localparam int unsigned BIT_PER_EN   = 1;
  localparam int unsigned BIT_TMP_PEND = 2;
  localparam int unsigned BIT_TMP_EN   = 3;
  localparam int unsigned BIT_SETCLR   = 7;
  localparam int unsigned STAT_W       = 4;
  localparam logic [7:0]  VEC_PERIOD   = 8'hFF;
  localparam logic [7:0]  VEC_TEMPO    = 8'hF7;
endpackage

// File: rtl/tirq_rst_sync.sv
module tirq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
  end

  assign rst_q_n = pipe_q[STAGES-1];
endmodule

// File: rtl/tirq_tempo_cnt.sv
module tirq_tempo_cnt #(
  parameter int unsigned LIM_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [LIM_W-1:0] limit_i,
  output logic             fire_o
);
  localparam int unsigned CNT_W = LIM_W + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovf_q, ovf_d;
  logic             reach;

  assign reach  = (cnt_q >= CNT_W'(limit_i));
  assign fire_o = tick_i && !ovf_q && reach;

  always_comb begin
    cnt_d = cnt_q;
    ovf_d = ovf_q;
    if (tick_i) begin
      cnt_d = ovf_q ? '0 : cnt_q + CNT_W'(1);
      ovf_d = reach && !ovf_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (tick_i) begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end
endmodule

// File: rtl/tirq_status.sv
module tirq_status
  import tirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              tempo_fire_i,
  input  logic              wr_en_i,
  input  logic [7:0]        wr_data_i,
  input  logic              ack_i,
  output logic [STAT_W-1:0] stat_o,
  output logic [7:0]        vec_o,
  output logic              irq_o
);
  logic [STAT_W-1:0] stat_q, stat_d;
  logic              tmp_req, per_req, ack_take;

  assign tmp_req  = stat_q[BIT_TMP_PEND] && stat_q[BIT_TMP_EN];
  assign per_req  = stat_q[BIT_PER_PEND] && stat_q[BIT_PER_EN];
  assign irq_o    = tmp_req || per_req;
  assign ack_take = ack_i && irq_o;

  always_comb begin
    if (tmp_req) vec_o = VEC_TEMPO;
    else         vec_o = VEC_PERIOD;
  end

  // order: acknowledge clear, then register write, then event sets
  always_comb begin
    stat_d = stat_q;
    if (ack_take) begin
      if (tmp_req) stat_d[BIT_TMP_PEND] = 1'b0;
      else         stat_d[BIT_PER_PEND] = 1'b0;
    end
    if (wr_en_i) begin
      if (wr_data_i[BIT_SETCLR]) stat_d = stat_d | wr_data_i[STAT_W-1:0];
      else                       stat_d = stat_d & ~wr_data_i[STAT_W-1:0];
    end
    if (tick_i)       stat_d[BIT_PER_PEND] = 1'b1;
    if (tempo_fire_i) stat_d[BIT_TMP_PEND] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/tempo_irq_ctrl.sv
module tempo_irq_ctrl
  import tirq_pkg::*;
#(
  parameter int unsigned LIM_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [LIM_W-1:0] limit_i,
  input  logic             wr_en_i,
  input  logic [7:0]       wr_data_i,
  output logic [7:0]       rd_data_o,
  input  logic             ack_i,
  output logic [7:0]       vec_o,
  output logic             irq_o
);
  logic              rst_q_n;
  logic              tempo_fire;
  logic [STAT_W-1:0] stat;

  tirq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n)
  );

  tirq_tempo_cnt #(.LIM_W(LIM_W)) u_cnt (
    .clk(clk), .rst_n(rst_q_n), .tick_i(tick_i),
    .limit_i(limit_i), .fire_o(tempo_fire)
  );

  tirq_status u_stat (
    .clk(clk), .rst_n(rst_q_n), .tick_i(tick_i),
    .tempo_fire_i(tempo_fire), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .ack_i(ack_i), .stat_o(stat), .vec_o(vec_o), .irq_o(irq_o)
  );

  assign rd_data_o = {{(8-STAT_W){1'b0}}, stat};
endmodule

// File: rtl/tempo_irq_ctrl_chk.sv
module tempo_irq_ctrl_chk (
  input logic       clk,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       wr_en_i,
  input logic [7:0] wr_data_i,
  input logic       ack_i,
  input logic [7:0] rd_data_o,
  input logic [7:0] vec_o,
  input logic       irq_o
);
  p_tick_sets_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    tick_i |=> rd_data_o[0]);

  p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    rd_data_o[7:4] == 4'h0);

  p_no_req_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (!rd_data_o[3] && !rd_data_o[1]) |-> !irq_o);

  p_tempo_first_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    (rd_data_o[3] && rd_data_o[2]) |-> (irq_o && vec_o == 8'hF7));

  p_wr_set_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[7]) |=>
      ((rd_data_o[3:0] & $past(wr_data_i[3:0])) == $past(wr_data_i[3:0])));

  p_wr_clr_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en_i && !wr_data_i[7] && !tick_i) |=>
      ((rd_data_o[3:0] & $past(wr_data_i[3:0])) == 4'h0));

  p_ack_tempo_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    (ack_i && irq_o && vec_o == 8'hF7 && !tick_i && !wr_en_i) |=> !rd_data_o[2]);

  p_idle_ack_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    (ack_i && !irq_o && !tick_i && !wr_en_i) |=> $stable(rd_data_o));
endmodule

bind tempo_irq_ctrl tempo_irq_ctrl_chk u_chk (
  .clk(clk), .rst_ni(rst_q_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
  .wr_data_i(wr_data_i), .ack_i(ack_i), .rd_data_o(rd_data_o),
  .vec_o(vec_o), .irq_o(irq_o)
);

// File: tb/tb_tempo_irq_ctrl.sv
`timescale 1ns/1ps
module tb_tempo_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic [11:0] limit_i = 12'hFFF;
  logic        wr_en_i = 1'b0;
  logic [7:0]  wr_data_i = 8'h00;
  logic        ack_i = 1'b0;
  logic [7:0]  rd_data_o, vec_o;
  logic        irq_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tempo_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .limit_i(limit_i),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o),
    .ack_i(ack_i), .vec_o(vec_o), .irq_o(irq_o)
  );

  // op: 0 write, 1 ack, 2 tick ; data ; expected rd, irq, vec
  typedef struct packed {
    logic [1:0] op;
    logic [7:0] data;
    logic [7:0] rd;
    logic       irq;
    logic [7:0] vec;
  } vec_t;

  localparam vec_t TBL [12] = '{
    '{2'd0, 8'h82, 8'h02, 1'b0, 8'hFF},
    '{2'd2, 8'h00, 8'h03, 1'b1, 8'hFF},
    '{2'd1, 8'h00, 8'h02, 1'b0, 8'hFF},
    '{2'd0, 8'h8C, 8'h0E, 1'b1, 8'hF7},
    '{2'd2, 8'h00, 8'h0F, 1'b1, 8'hF7},
    '{2'd1, 8'h00, 8'h0B, 1'b1, 8'hFF},
    '{2'd1, 8'h00, 8'h0A, 1'b0, 8'hFF},
    '{2'd0, 8'h0A, 8'h00, 1'b0, 8'hFF},
    '{2'd0, 8'h85, 8'h05, 1'b0, 8'hFF},
    '{2'd1, 8'h00, 8'h05, 1'b0, 8'hFF},
    '{2'd0, 8'h88, 8'h0D, 1'b1, 8'hF7},
    '{2'd0, 8'h0C, 8'h01, 1'b0, 8'hFF}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] op, input logic [7:0] d);
    @(negedge clk);
    wr_en_i = (op == 2'd0); wr_data_i = d;
    ack_i = (op == 2'd1); tick_i = (op == 2'd2);
    @(negedge clk);
    wr_en_i = 1'b0; ack_i = 1'b0; tick_i = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // ticks until tempo pending appears, then clears it
  task automatic ticks_to_tempo(output int n);
    n = 0;
    while (rd_data_o[2] == 1'b0 && n < 6000) begin
      step(2'd2, 8'h00);
      n++;
    end
    step(2'd0, 8'h04);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    do_reset();
    chk("R1 rd", rd_data_o, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 vec", vec_o, 8'hFF);

    // R2 R3 R4 R7 R8 R9 table walk
    foreach (TBL[i]) begin
      step(TBL[i].op, TBL[i].data);
      chk($sformatf("R3/R7/R8/R9 row%0d rd", i), rd_data_o, TBL[i].rd);
      chk($sformatf("R7 row%0d irq", i), irq_o, TBL[i].irq);
      chk($sformatf("R8 row%0d vec", i), vec_o, TBL[i].vec);
    end

    // R5 X=0: first at tick 1, then every 2
    limit_i = 12'd0; do_reset();
    ticks_to_tempo(n); chk("R5 X0 first", n, 1);
    ticks_to_tempo(n); chk("R5 X0 period", n, 2);
    ticks_to_tempo(n); chk("R5 X0 period2", n, 2);

    // R5 X=3: first at tick 4, then every 5
    limit_i = 12'd3; do_reset();
    ticks_to_tempo(n); chk("R5 X3 first", n, 4);
    ticks_to_tempo(n); chk("R5 X3 period", n, 5);

    // R6 lower limit below reached count
    limit_i = 12'd100; do_reset();
    for (int k = 0; k < 50; k++) step(2'd2, 8'h00);
    chk("R6 no early", rd_data_o[2], 0);
    limit_i = 12'd10;
    ticks_to_tempo(n); chk("R6 immediate", n, 1);
    ticks_to_tempo(n); chk("R6 new period", n, 12);

    // R11 coincident events, tempo first
    limit_i = 12'd0; do_reset();
    step(2'd0, 8'h8A);
    step(2'd2, 8'h00);
    chk("R11 both pend", rd_data_o, 8'h0F);
    chk("R11 vec tempo", vec_o, 8'hF7);
    step(2'd1, 8'h00);
    chk("R11 vec period next", vec_o, 8'hFF);
    chk("R11 irq still", irq_o, 1);

    // R10 ack together with tick: set wins
    @(negedge clk); ack_i = 1'b1; tick_i = 1'b1;
    @(negedge clk); ack_i = 1'b0; tick_i = 1'b0;
    chk("R10 tick over ack", rd_data_o[0], 1);
    // R10 ack together with set write
    step(2'd0, 8'h04);
    @(negedge clk); ack_i = 1'b1; wr_en_i = 1'b1; wr_data_i = 8'h81;
    @(negedge clk); ack_i = 1'b0; wr_en_i = 1'b0;
    chk("R10 write over ack", rd_data_o[0], 1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule